// File: doc/BRIEF.md
# Port Status LED Driver

This block drives the three active-low indicator lamps of a single Ethernet port. The first lamp shows link state and traffic. The second shows the line rate. The third shows collisions. The block takes the port's link state, a rate flag, a one-cycle activity strobe and a one-cycle collision strobe. It turns these into lamp levels that a person can see. All timing comes from the system clock, using counters sized from a clock-frequency parameter.

Traffic is measured as the number of strobed cycles inside a fixed measurement window. At the end of each window the count is sorted into an idle band or one of three traffic bands. The band is held until the next window closes. The traffic lamp blinks at the rate of the held band. Collisions are stretched into a pulse long enough to see. After every reset, all three lamps are forced on for a timed self-test interval.

Top module: `port_led_driver`

## Requirements
- R1: All three lamp outputs are low while `rst` is high. They stay low for the first TEST_CYC-1 rising edges after `rst` falls, where TEST_CYC = CLK_HZ*TEST_MS/1000. From edge TEST_CYC onward the lamps show normal state.
- R2: When the link is up and the last completed window held zero activity cycles, the link lamp is steadily low.
- R3: Let N be the number of activity cycles in a window of W = CLK_HZ*WIN_MS/1000 cycles. When N > 0 and N*20 < W, the link lamp blinks with half period CLK_HZ/(2*SLOW_HZ). Otherwise, when N*10 < 3*W, it uses CLK_HZ/(2*MED_HZ). Otherwise it uses CLK_HZ/(2*FAST_HZ).
- R4: While blinking, the low (on) and high (off) halves have equal length.
- R5: Outside the self-test, the speed lamp is low when `spd100_i` is 1 and high when it is 0.
- R6: A collision strobe sampled at a rising edge drives the collision lamp low from that edge for exactly STRETCH_CYC = CLK_HZ*STRETCH_MS/1000 cycles.
- R7: A collision strobe that arrives during a stretch restarts the full STRETCH_CYC interval from its own edge.
- R8: While the link is down, the link lamp is high whatever the traffic. When the link comes back with traffic, blinking restarts in the on (low) half.
- R9: The collision stretch runs independently of the self-test. A collision taken near the end of the test keeps its lamp low after the other lamps are released, until its own interval ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; starts the lamp self-test |
| link_up_i | input | 1 | Link is good |
| spd100_i | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| act_i | input | 1 | One cycle of transfer activity |
| col_i | input | 1 | Collision strobe |
| led_link_n_o | output | 1 | Link/traffic lamp, active low |
| led_spd_n_o | output | 1 | Speed lamp, active low |
| led_col_n_o | output | 1 | Collision lamp, active low |

## Verification
The self-test and the collision stretch can both hold the collision lamp in the same cycle. The bench provokes this by issuing a collision strobe nine edges before the self-test expires. It then judges that the speed and link lamps are released on the exact test edge, while the collision lamp stays low until 41 edges after the strobe was taken. Band boundaries are probed with repeating activity patterns whose per-window counts sit exactly at and just below the 5% and 30% thresholds. Half periods are measured between successive lamp transitions.

// File: rtl/led_pkg.sv
package led_pkg;

    typedef enum logic [1:0] {
        BAND_IDLE = 2'd0,
        BAND_SLOW = 2'd1,
        BAND_MED  = 2'd2,
        BAND_FAST = 2'd3
    } band_e;

    // Converts milliseconds to clock cycles at the given frequency.
    function automatic longint unsigned ms_to_cyc(longint unsigned hz, longint unsigned ms);
        return (hz * ms) / 64'd1000;
    endfunction

    // Sorts a window activity count into a traffic band (5% and 30% limits).
    function automatic band_e classify(longint unsigned cnt, longint unsigned win);
        if (cnt == 0)
            return BAND_IDLE;
        else if (cnt * 20 < win)
            return BAND_SLOW;
        else if (cnt * 10 < win * 3)
            return BAND_MED;
        else
            return BAND_FAST;
    endfunction

endpackage

// File: rtl/led_stretch.sv
// Loadable down-counter; busy while nonzero.
module led_stretch #(
    parameter int unsigned CYC = 42
) (
    input  logic clk,
    input  logic clr,
    input  logic load,
    output logic busy
);
    localparam int unsigned W = $clog2(CYC + 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (clr)
            cnt_q <= '0;
        else if (load)
            cnt_q <= W'(CYC);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/led_util_meter.sv
// Counts activity over a fixed window and latches the band at window end.
module led_util_meter
    import led_pkg::*;
#(
    parameter int unsigned WIN_CYC = 420
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  act,
    output band_e band
);
    localparam int unsigned W = $clog2(WIN_CYC + 1);

    logic [W-1:0] win_q;
    logic [W-1:0] act_q;
    logic [W-1:0] act_next;
    band_e        band_q;

    assign act_next = act_q + W'(act);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q  <= '0;
            act_q  <= '0;
            band_q <= BAND_IDLE;
        end else if (win_q == W'(WIN_CYC - 1)) begin
            win_q  <= '0;
            act_q  <= '0;
            band_q <= classify(64'(act_next), 64'(WIN_CYC));
        end else begin
            win_q <= win_q + 1'b1;
            act_q <= act_next;
        end
    end

    assign band = band_q;
endmodule

// File: rtl/led_blinker.sv
// Square-wave generator with band-selected half period; starts in the on half.
module led_blinker
    import led_pkg::*;
#(
    parameter int unsigned HALF_SLOW = 700,
    parameter int unsigned HALF_MED  = 420,
    parameter int unsigned HALF_FAST = 300
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  band_e band,
    output logic  on
);
    localparam int unsigned HMAX_A = (HALF_SLOW > HALF_MED) ? HALF_SLOW : HALF_MED;
    localparam int unsigned HMAX   = (HMAX_A > HALF_FAST) ? HMAX_A : HALF_FAST;
    localparam int unsigned W      = $clog2(HMAX + 1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] half;
    logic         off_q;

    always_comb begin
        case (band)
            BAND_FAST: half = W'(HALF_FAST);
            BAND_MED:  half = W'(HALF_MED);
            default:   half = W'(HALF_SLOW);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
            off_q <= 1'b0;
        end else if (cnt_q >= half - 1'b1) begin
            cnt_q <= '0;
            off_q <= ~off_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign on = ~off_q;
endmodule

// File: rtl/port_led_driver.sv
module port_led_driver
    import led_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned TEST_MS    = 2000,
    parameter int unsigned STRETCH_MS = 10,
    parameter int unsigned WIN_MS     = 100,
    parameter int unsigned SLOW_HZ    = 3,
    parameter int unsigned MED_HZ     = 5,
    parameter int unsigned FAST_HZ    = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic link_up_i,
    input  logic spd100_i,
    input  logic act_i,
    input  logic col_i,
    output logic led_link_n_o,
    output logic led_spd_n_o,
    output logic led_col_n_o
);
    localparam int unsigned TEST_CYC    = int'(ms_to_cyc(64'(CLK_HZ), 64'(TEST_MS)));
    localparam int unsigned STRETCH_CYC = int'(ms_to_cyc(64'(CLK_HZ), 64'(STRETCH_MS)));
    localparam int unsigned WIN_CYC     = int'(ms_to_cyc(64'(CLK_HZ), 64'(WIN_MS)));
    localparam int unsigned HALF_SLOW   = CLK_HZ / (2 * SLOW_HZ);
    localparam int unsigned HALF_MED    = CLK_HZ / (2 * MED_HZ);
    localparam int unsigned HALF_FAST   = CLK_HZ / (2 * FAST_HZ);

    logic  lamp_on;
    logic  col_busy;
    logic  blink_on;
    logic  blink_en;
    band_e band_q;

    led_stretch #(.CYC(TEST_CYC)) u_lamp (
        .clk  (clk),
        .clr  (1'b0),
        .load (rst),
        .busy (lamp_on)
    );

    led_stretch #(.CYC(STRETCH_CYC)) u_col (
        .clk  (clk),
        .clr  (rst),
        .load (col_i),
        .busy (col_busy)
    );

    led_util_meter #(.WIN_CYC(WIN_CYC)) u_meter (
        .clk  (clk),
        .rst  (rst),
        .act  (act_i),
        .band (band_q)
    );

    assign blink_en = link_up_i && (band_q != BAND_IDLE);

    led_blinker #(
        .HALF_SLOW (HALF_SLOW),
        .HALF_MED  (HALF_MED),
        .HALF_FAST (HALF_FAST)
    ) u_blink (
        .clk  (clk),
        .rst  (rst),
        .en   (blink_en),
        .band (band_q),
        .on   (blink_on)
    );

    assign led_link_n_o = lamp_on ? 1'b0
                        : ~(link_up_i && ((band_q == BAND_IDLE) || blink_on));
    assign led_spd_n_o  = lamp_on ? 1'b0 : ~spd100_i;
    assign led_col_n_o  = ~(lamp_on | col_busy);
endmodule

// File: rtl/led_checker.sv
module led_checker
    import led_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  link_up_i,
    input logic  spd100_i,
    input logic  col_i,
    input logic  led_link_n_o,
    input logic  led_spd_n_o,
    input logic  led_col_n_o,
    input logic  lamp,
    input band_e band
);
    // R1: self-test forces every lamp on
    a_r1_lamp_all_on: assert property (@(posedge clk) disable iff (rst)
        lamp |-> (!led_link_n_o && !led_spd_n_o && !led_col_n_o));

    // R1: self-test is running on the first edge after reset
    a_r1_test_starts: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> lamp);

    // R5: 100 Mb/s always lights the speed lamp
    a_r5_speed_on: assert property (@(posedge clk) disable iff (rst)
        spd100_i |-> !led_spd_n_o);

    // R6: a sampled collision lights the lamp on the next cycle
    a_r6_col_lit: assert property (@(posedge clk) disable iff (rst)
        col_i |=> !led_col_n_o);

    // R8: link down keeps the link lamp dark outside self-test
    a_r8_link_down_dark: assert property (@(posedge clk) disable iff (rst)
        (!link_up_i && !lamp) |-> led_link_n_o);

    // R2: idle band with link up keeps the lamp steadily on
    a_r2_idle_solid: assert property (@(posedge clk) disable iff (rst)
        (link_up_i && band == BAND_IDLE) |-> !led_link_n_o);
endmodule

bind port_led_driver led_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .link_up_i    (link_up_i),
    .spd100_i     (spd100_i),
    .col_i        (col_i),
    .led_link_n_o (led_link_n_o),
    .led_spd_n_o  (led_spd_n_o),
    .led_col_n_o  (led_col_n_o),
    .lamp         (lamp_on),
    .band         (band_q)
);

// File: tb/sim_port_led_driver.sv
`timescale 1ns/1ps
module sim_port_led_driver;
    localparam int CLK_HZ  = 4200;
    localparam int TEST    = 8400;  // 2000 ms
    localparam int STRETCH = 42;    // 10 ms
    localparam int WIN     = 420;   // 100 ms
    localparam int H_SLOW  = 700;
    localparam int H_MED   = 420;
    localparam int H_FAST  = 300;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic link_up = 1'b0;
    logic spd100 = 1'b0;
    logic act = 1'b0;
    logic col = 1'b0;
    logic led_link_n, led_spd_n, led_col_n;

    int checks = 0;
    int errors = 0;
    int act_num = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    port_led_driver #(.CLK_HZ(CLK_HZ)) u0 (
        .clk          (clk),
        .rst          (rst),
        .link_up_i    (link_up),
        .spd100_i     (spd100),
        .act_i        (act),
        .col_i        (col),
        .led_link_n_o (led_link_n),
        .led_spd_n_o  (led_spd_n),
        .led_col_n_o  (led_col_n)
    );

    // Activity pattern repeating every WIN cycles with act_num active cycles.
    initial begin
        int g = 0;
        forever begin
            @(posedge clk);
            #1;
            g = (g == WIN - 1) ? 0 : g + 1;
            act = (g < act_num);
        end
    end

    task automatic check(input bit ok, input string req, input int actual, input int expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step(3);
        rst = 1'b0;
    endtask

    // Cycles between two successive transitions of the link lamp.
    task automatic measure_half(output int len);
        logic v;
        int guard = 0;
        v = led_link_n;
        while (led_link_n == v && guard < 3000) begin
            step(1);
            guard++;
        end
        v = led_link_n;
        len = 0;
        while (led_link_n == v && len < 3000) begin
            step(1);
            len++;
        end
    endtask

    task automatic t_lamp_test();
        rst = 1'b1;
        step(3);
        check(!led_link_n && !led_spd_n && !led_col_n, "R1 in reset",
              {led_link_n, led_spd_n, led_col_n}, 0);
        rst = 1'b0;
        step(TEST - 1);
        check(!led_link_n && !led_spd_n && !led_col_n, "R1 last test edge",
              {led_link_n, led_spd_n, led_col_n}, 0);
        step(1);
        check(led_link_n && led_spd_n && led_col_n, "R1 released",
              {led_link_n, led_spd_n, led_col_n}, 7);
    endtask

    task automatic t_speed();
        spd100 = 1'b1;
        #1;
        check(!led_spd_n, "R5 100M", led_spd_n, 0);
        spd100 = 1'b0;
        #1;
        check(led_spd_n, "R5 10M", led_spd_n, 1);
    endtask

    task automatic t_link_down();
        int bad = 0;
        link_up = 1'b0;
        act_num = 126;
        step(2 * WIN);
        for (int i = 0; i < 800; i++) begin
            if (!led_link_n) bad++;
            step(1);
        end
        check(bad == 0, "R8 link down dark", bad, 0);
    endtask

    task automatic t_idle();
        int bad = 0;
        link_up = 1'b1;
        act_num = 0;
        step(2 * WIN + 5);
        for (int i = 0; i < 800; i++) begin
            if (led_link_n) bad++;
            step(1);
        end
        check(bad == 0, "R2 idle solid on", bad, 0);
    endtask

    task automatic t_band(input int n, input int half, input string req);
        int a, b;
        link_up = 1'b1;
        act_num = n;
        step(2 * WIN + 5);
        measure_half(a);
        measure_half(b);
        check(a == half, req, a, half);
        check(a == b, "R4 equal halves", b, a);
    endtask

    task automatic t_link_return();
        link_up = 1'b0;
        act_num = 126;
        step(50);
        link_up = 1'b1;
        #1;
        check(!led_link_n, "R8 restart on half", led_link_n, 0);
        step(H_FAST - 1);
        check(!led_link_n, "R8 on half length", led_link_n, 0);
        step(1);
        check(led_link_n, "R8 first off", led_link_n, 1);
    endtask

    task automatic t_collision();
        col = 1'b1;
        step(1);
        col = 1'b0;
        check(!led_col_n, "R6 lit", led_col_n, 0);
        step(STRETCH - 1);
        check(!led_col_n, "R6 last cycle", led_col_n, 0);
        step(1);
        check(led_col_n, "R6 released", led_col_n, 1);
    endtask

    task automatic t_retrigger();
        col = 1'b1;
        step(1);
        col = 1'b0;
        step(30);
        col = 1'b1;
        step(1);
        col = 1'b0;
        step(STRETCH - 1);
        check(!led_col_n, "R7 extended", led_col_n, 0);
        step(1);
        check(led_col_n, "R7 released", led_col_n, 1);
    endtask

    task automatic t_col_across_test();
        link_up = 1'b0;
        spd100 = 1'b0;
        do_reset();
        step(TEST - 10);
        col = 1'b1;
        step(1);
        col = 1'b0;
        step(9);
        check(led_spd_n && led_link_n, "R9 others released",
              {led_link_n, led_spd_n}, 3);
        check(!led_col_n, "R9 col still lit", led_col_n, 0);
        step(32);
        check(!led_col_n, "R9 col last cycle", led_col_n, 0);
        step(1);
        check(led_col_n, "R9 col released", led_col_n, 1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_lamp_test();
        t_speed();
        t_link_down();
        t_idle();
        t_band(20,  H_SLOW, "R3 slow below 5%");
        t_band(21,  H_MED,  "R3 medium at 5%");
        t_band(125, H_MED,  "R3 medium below 30%");
        t_band(126, H_FAST, "R3 fast at 30%");
        t_link_return();
        t_collision();
        t_retrigger();
        t_col_across_test();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule